// File: doc/BRIEF.md
# Programmable Slot-Mapped 7:1 Lane Serializer

This block turns one parallel pixel word per pixel period into serial lane bits for a differential display link. Each pixel period lasts seven cycles of the fast serial clock. There are two channels with four data lanes each. For every lane, each of the seven serial time slots has its own 5-bit selector. The selector names the source bit carried in that slot. The 28 possible source bits are the 24 colour bits, horizontal sync, vertical sync, data-enable and one spare bit. Because the mapping is fully programmable, any standard or custom bit ordering is a matter of configuration.

The configuration inputs set the colour depth (18-bit or 24-bit), one or two channels, and a channel exchange. A separate serializer enable is raised only after the rest of the configuration has settled. Lanes that the mode leaves unused, and both channels while the serializer is off, drive a constant 0. Each channel also has a clock lane that repeats a fixed seven-slot pattern aligned with the data lanes. The block also registers two mode flags for downstream logic: a reduced-colour flag and a single-channel flag.

Top module: `lvds_slot_mux_ser`

## Requirements
- R1: Selector value v picks `pix_rgb[v]` for v from 0 to 23, `pix_hsync` for 24, `pix_vsync` for 25, `pix_de` for 26 and `pix_spare` for 27. The values 28 to 31 yield 0.
- R2: The selector for logical channel c, lane l and slot s sits at bit offset ((c*4+l)*7+s)*5 of `cfg_slot_sel`. Each pixel period lasts 7 serial cycles. The pixel and configuration are sampled on the load edge. The lane then presents slot 6 first and slot 0 last, one slot per cycle, starting in the cycle after the load edge.
- R3: An active clock lane repeats the pattern 1,1,0,0,0,1,1. Its first 1 appears in the same cycle as data slot 6.
- R4: With `cfg_depth24`=1, all four lanes of an active channel carry data. With `cfg_depth24`=0, lane 3 of each channel stays at 0.
- R5: With `cfg_dual`=0, the data lanes and the clock lane of logical channel 1 stay at 0. Logical channel 0 is always active.
- R6: With `cfg_swap`=0, physical lanes 0..3 of `lane_sd` and bit 0 of `clk_lane` carry logical channel 0, and the upper bits carry logical channel 1. With `cfg_swap`=1, the two channels exchange positions.
- R7: While `cfg_ser_en` is 0, every lane and clock output is 0 in the following cycle. The first load happens on the first rising edge with `cfg_ser_en` high. Loads then repeat every 7 edges.
- R8: `narrow_rgb` equals the inverse of `cfg_depth24`, and `single_link` equals the inverse of `cfg_dual`. Both are registered one cycle after the configuration.
- R9: While `rst_n` is low at a clock edge, all outputs are 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock, seven cycles per pixel |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_rgb | input | 24 | Colour bits of the current pixel |
| pix_hsync | input | 1 | Horizontal sync (source 24) |
| pix_vsync | input | 1 | Vertical sync (source 25) |
| pix_de | input | 1 | Data enable (source 26) |
| pix_spare | input | 1 | Spare control bit (source 27) |
| cfg_slot_sel | input | 280 | 56 slot selectors of 5 bits each |
| cfg_depth24 | input | 1 | 1: 24-bit colour, 0: 18-bit colour |
| cfg_dual | input | 1 | 1: both channels active |
| cfg_swap | input | 1 | Exchange channel outputs |
| cfg_ser_en | input | 1 | Serializer enable |
| lane_sd | output | 8 | Serial data, physical channel 0 in bits 3..0 |
| clk_lane | output | 2 | Clock lane of each physical channel |
| narrow_rgb | output | 1 | 18-bit colour mode flag |
| single_link | output | 1 | Single-channel mode flag |

## Verification
The pixel and the configuration are sampled on the load edge. The lane bit for slot 6 appears after that edge, and slot 0 appears six edges later. The next load follows on the seventh edge. The bench drives all inputs on falling edges and holds the pixel stable for the whole period. It samples the outputs on the falling edge after each of the seven rising edges, and compares them with slot 6 minus the edge count. Disabling the serializer is checked one edge later. The two mode flags are likewise checked one edge after the configuration changes.

// File: rtl/lvds_mux_pkg.sv
// Shared constants and helpers for the slot-mapped lane serializer.
// Assumes a 5-bit selector and a fixed set of four control sources above the colour bits.
package lvds_mux_pkg;
    localparam int SLOTS      = 7;
    localparam int SEL_W      = 5;
    localparam int CTRL_SRCS  = 4;
    localparam logic [SLOTS-1:0] CLK_PATTERN = 7'b1100011;

    // Enable rule for one lane: channel active and lane within the colour depth.
    function automatic logic lane_active(input int ch, input int lane, input int lanes_per_ch,
                                         input logic dual, input logic depth24);
        return ((ch == 0) || dual) && ((lane < lanes_per_ch - 1) || depth24);
    endfunction
endpackage

// File: rtl/lane_gather.sv
// Builds one lane's seven-slot word from the source vector.
// Each slot has its own selector; a selector beyond the source count yields 0.
// Assumes sel holds SLOTS fields of SEL_W bits, slot 0 in the lowest field.
module lane_gather #(
    parameter int SLOTS    = 7,
    parameter int SEL_W    = 5,
    parameter int SRC_BITS = 28
) (
    input  logic [SRC_BITS-1:0]    src,
    input  logic [SLOTS*SEL_W-1:0] sel,
    output logic [SLOTS-1:0]       word
);
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic [SEL_W-1:0] idx;
        assign idx = sel[s*SEL_W +: SEL_W];
        // One selector mux per slot, guarded against indices past the source set.
        always_comb begin
            word[s] = 1'b0;
            for (int k = 0; k < SRC_BITS; k++) begin
                if (int'(idx) == k) word[s] = src[k];
            end
        end
    end
endmodule

// File: rtl/ser_phase_ctrl.sv
// Pixel-period phase counter for the serializer.
// Issues a load strobe on the first enabled edge and then every SLOTS edges.
// Assumes the enable is held for whole periods; dropping it restarts the phase.
module ser_phase_ctrl #(
    parameter int SLOTS = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic load
);
    localparam int PH_W = $clog2(SLOTS);
    localparam logic [PH_W-1:0] LAST = PH_W'(SLOTS - 1);

    logic [PH_W-1:0] phase;

    assign load = en && (phase == '0);

    // Advance the slot phase while enabled, park at 0 otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)      phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                    phase <= phase + 1'b1;
    end

    a_r2_phase_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= LAST);
    a_r7_wrap_to_load: assert property (@(posedge clk) disable iff (!rst_n)
        (en && phase == LAST) |=> (phase == '0));
    a_r7_idle_parks: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (phase == '0));
endmodule

// File: rtl/lane_shifter.sv
// Seven-slot parallel-in serial-out register for one lane.
// Loads a word on the load strobe and shifts toward the top bit, which is the output.
// Assumes load only arrives while en is high; en low clears the lane.
module lane_shifter #(
    parameter int SLOTS = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             load,
    input  logic [SLOTS-1:0] din,
    output logic             sout
);
    logic [SLOTS-1:0] sreg;

    // Load a fresh word, shift one slot, or clear when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) sreg <= '0;
        else if (load)     sreg <= din;
        else               sreg <= {sreg[SLOTS-2:0], 1'b0};
    end

    assign sout = sreg[SLOTS-1];

    a_r2_loaded_top_first: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (sout == $past(din[SLOTS-1])));
endmodule

// File: rtl/lvds_slot_mux_ser.sv
// Top of the slot-mapped 7:1 lane serializer.
// Gathers each lane's slot word from the pixel, masks lanes that the depth and
// channel mode leave unused, serializes slot 6 first, and produces the clock
// lanes. Assumes clk runs at seven times the pixel rate and the pixel is stable
// on each load edge. The channel exchange is applied after the shift registers.
module lvds_slot_mux_ser
    import lvds_mux_pkg::*;
#(
    parameter int LANES_PER_CH = 4,
    parameter int COLOR_BITS   = 24
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic [COLOR_BITS-1:0]                     pix_rgb,
    input  logic                                      pix_hsync,
    input  logic                                      pix_vsync,
    input  logic                                      pix_de,
    input  logic                                      pix_spare,
    input  logic [2*LANES_PER_CH*SLOTS*SEL_W-1:0]     cfg_slot_sel,
    input  logic                                      cfg_depth24,
    input  logic                                      cfg_dual,
    input  logic                                      cfg_swap,
    input  logic                                      cfg_ser_en,
    output logic [2*LANES_PER_CH-1:0]                 lane_sd,
    output logic [1:0]                                clk_lane,
    output logic                                      narrow_rgb,
    output logic                                      single_link
);
    localparam int NUM_CH    = 2;
    localparam int NUM_LANES = NUM_CH * LANES_PER_CH;
    localparam int SRC_BITS  = COLOR_BITS + CTRL_SRCS;
    localparam int LANE_SEL  = SLOTS * SEL_W;

    logic [SRC_BITS-1:0]                     src_vec;
    logic                                    load;
    logic [NUM_CH-1:0][LANES_PER_CH-1:0]     log_sd;
    logic [NUM_CH-1:0]                       log_ck;

    assign src_vec = {pix_spare, pix_de, pix_vsync, pix_hsync, pix_rgb};

    ser_phase_ctrl #(.SLOTS(SLOTS)) u_phase (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (cfg_ser_en),
        .load (load)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic ck_on;
        assign ck_on = (c == 0) || cfg_dual;

        for (genvar l = 0; l < LANES_PER_CH; l++) begin : g_lane
            logic [SLOTS-1:0] word;
            logic [SLOTS-1:0] word_masked;
            logic             on;

            lane_gather #(.SLOTS(SLOTS), .SEL_W(SEL_W), .SRC_BITS(SRC_BITS)) u_gather (
                .src (src_vec),
                .sel (cfg_slot_sel[(c*LANES_PER_CH + l)*LANE_SEL +: LANE_SEL]),
                .word(word)
            );

            assign on          = lane_active(c, l, LANES_PER_CH, cfg_dual, cfg_depth24);
            assign word_masked = on ? word : '0;

            lane_shifter #(.SLOTS(SLOTS)) u_shift (
                .clk  (clk),
                .rst_n(rst_n),
                .en   (cfg_ser_en),
                .load (load),
                .din  (word_masked),
                .sout (log_sd[c][l])
            );
        end

        lane_shifter #(.SLOTS(SLOTS)) u_clk_shift (
            .clk  (clk),
            .rst_n(rst_n),
            .en   (cfg_ser_en),
            .load (load),
            .din  (ck_on ? CLK_PATTERN : '0),
            .sout (log_ck[c])
        );
    end

    // Place the logical channels on the physical outputs, exchanged on request.
    always_comb begin
        if (cfg_swap) begin
            lane_sd  = {log_sd[0], log_sd[1]};
            clk_lane = {log_ck[0], log_ck[1]};
        end else begin
            lane_sd  = {log_sd[1], log_sd[0]};
            clk_lane = {log_ck[1], log_ck[0]};
        end
    end

    // Register the mode flags for downstream consumers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            narrow_rgb  <= 1'b0;
            single_link <= 1'b0;
        end else begin
            narrow_rgb  <= !cfg_depth24;
            single_link <= !cfg_dual;
        end
    end

    a_r7_idle_outputs_low: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ser_en |=> (log_sd == '0 && log_ck == '0));
    a_r3_clock_starts_high: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (log_ck[0] == 1'b1));
    a_r5_second_channel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !cfg_dual) |=> (log_sd[1] == '0 && log_ck[1] == 1'b0));
    a_r4_top_lane_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !cfg_depth24) |=> (log_sd[0][LANES_PER_CH-1] == 1'b0 &&
                                    log_sd[1][LANES_PER_CH-1] == 1'b0));
    a_r6_swap_exchanges: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_swap |-> (lane_sd[LANES_PER_CH-1:0] == log_sd[1] && clk_lane[0] == log_ck[1]));
    a_r8_flags_follow: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (narrow_rgb == !$past(cfg_depth24) && single_link == !$past(cfg_dual)));
endmodule

// File: tb/test_lvds_slot_mux_ser.sv
module test_lvds_slot_mux_ser;
    localparam int LPC = 4;
    localparam int NL  = 8;
    localparam int SL  = 7;
    localparam int SW  = 5;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic             rst_n;
    logic [23:0]      pix_rgb;
    logic             pix_hsync, pix_vsync, pix_de, pix_spare;
    logic [NL*SL*SW-1:0] cfg_slot_sel;
    logic             cfg_depth24, cfg_dual, cfg_swap, cfg_ser_en;
    logic [NL-1:0]    lane_sd;
    logic [1:0]       clk_lane;
    logic             narrow_rgb, single_link;

    int checks = 0;
    int errors = 0;

    lvds_slot_mux_ser i_lvds_slot_mux_ser (
        .clk(clk), .rst_n(rst_n), .pix_rgb(pix_rgb), .pix_hsync(pix_hsync),
        .pix_vsync(pix_vsync), .pix_de(pix_de), .pix_spare(pix_spare),
        .cfg_slot_sel(cfg_slot_sel), .cfg_depth24(cfg_depth24), .cfg_dual(cfg_dual),
        .cfg_swap(cfg_swap), .cfg_ser_en(cfg_ser_en), .lane_sd(lane_sd),
        .clk_lane(clk_lane), .narrow_rgb(narrow_rgb), .single_link(single_link)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // R1 source map.
    function automatic logic src_bit(input int idx);
        if (idx < 24)  return pix_rgb[idx];
        if (idx == 24) return pix_hsync;
        if (idx == 25) return pix_vsync;
        if (idx == 26) return pix_de;
        if (idx == 27) return pix_spare;
        return 1'b0;
    endfunction

    // R2 field placement, R4/R5 lane masks.
    function automatic logic [6:0] exp_word(input int c, input int l);
        logic [6:0] w = '0;
        logic on = ((c == 0) || cfg_dual) && ((l < LPC - 1) || cfg_depth24);
        for (int s = 0; s < SL; s++)
            w[s] = on && src_bit(int'(cfg_slot_sel[((c*LPC + l)*SL + s)*SW +: SW]));
        return w;
    endfunction

    // Expected {clk_lane, lane_sd} after the b-th edge of a period (R2, R3, R6).
    function automatic logic [9:0] exp_phys(input int b);
        logic [3:0] ch [2];
        logic [1:0] ck;
        logic [6:0] pat = 7'b1100011;
        for (int c = 0; c < 2; c++) begin
            for (int l = 0; l < LPC; l++) ch[c][l] = exp_word(c, l)[6-b];
            ck[c] = ((c == 0) || cfg_dual) && pat[6-b];
        end
        if (cfg_swap) return {ck[0], ck[1], ch[0], ch[1]};
        return {ck[1], ck[0], ch[1], ch[0]};
    endfunction

    task automatic rand_pixel();
        pix_rgb   = 24'($urandom);
        pix_hsync = 1'($urandom);
        pix_vsync = 1'($urandom);
        pix_de    = 1'($urandom);
        pix_spare = 1'($urandom);
    endtask

    task automatic rand_sel();
        for (int i = 0; i < NL*SL; i++) cfg_slot_sel[i*SW +: SW] = 5'($urandom_range(0, 31));
    endtask

    // Called at a falling edge with the serializer off; runs n pixels, then disables.
    task automatic run_pixels(input int n, input string req, input bit randpix);
        cfg_ser_en = 1'b1;
        for (int k = 0; k < n; k++) begin
            if (randpix) rand_pixel();
            for (int b = 0; b < SL; b++) begin
                @(posedge clk); @(negedge clk);
                chk(req, 32'({clk_lane, lane_sd}), 32'(exp_phys(b)));
            end
        end
        cfg_ser_en = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R7 idle after disable", 32'({clk_lane, lane_sd}), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual running expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h5eed);
        rst_n = 1'b0;
        pix_rgb = '0; pix_hsync = 0; pix_vsync = 0; pix_de = 0; pix_spare = 0;
        cfg_slot_sel = '0; cfg_depth24 = 1; cfg_dual = 1; cfg_swap = 0; cfg_ser_en = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 reset lanes", 32'({clk_lane, lane_sd}), 32'd0);
        chk("R9 reset flags", 32'({narrow_rgb, single_link}), 32'd0);
        cfg_ser_en = 1'b0;
        rst_n = 1'b1;

        // R8 flags follow configuration one edge later.
        cfg_depth24 = 0; cfg_dual = 0;
        @(posedge clk); @(negedge clk);
        chk("R8 flags narrow single", 32'({narrow_rgb, single_link}), 32'h3);
        cfg_depth24 = 1; cfg_dual = 1;
        @(posedge clk); @(negedge clk);
        chk("R8 flags wide dual", 32'({narrow_rgb, single_link}), 32'h0);

        // R2 directed example mapping on logical lane 0, 24-bit, single channel.
        rand_sel();
        cfg_slot_sel[0 +: SL*SW] = {5'h00, 5'h01, 5'h02, 5'h03, 5'h04, 5'h05, 5'h08};
        cfg_depth24 = 1; cfg_dual = 0; cfg_swap = 0;
        pix_rgb = 24'h000125;
        run_pixels(1, "R2 example slot order", 1'b0);
        // Lane 0 serial order for rgb 0x125: slots 6..0 = bits 0,1,2,3,4,5,8.
        rand_sel();

        // R1 control sources and out-of-range selectors.
        for (int i = 0; i < NL*SL; i++) cfg_slot_sel[i*SW +: SW] = 5'(24 + (i % 8));
        cfg_dual = 1;
        run_pixels(6, "R1 control and unused sources", 1'b1);

        // R4 18-bit mode with all-ones pixel: top lane must stay 0.
        for (int i = 0; i < NL*SL; i++) cfg_slot_sel[i*SW +: SW] = 5'($urandom_range(0, 27));
        cfg_depth24 = 0; cfg_dual = 1;
        pix_rgb = '1; pix_hsync = 1; pix_vsync = 1; pix_de = 1; pix_spare = 1;
        run_pixels(2, "R4 narrow top lane off", 1'b0);

        // R5 single channel, R6 swap.
        cfg_depth24 = 1; cfg_dual = 0; cfg_swap = 1;
        run_pixels(2, "R5 R6 single swapped", 1'b0);

        // R7 disable mid-period.
        cfg_dual = 1; cfg_swap = 0; cfg_ser_en = 1;
        rand_pixel();
        repeat (3) @(posedge clk);
        @(negedge clk);
        cfg_ser_en = 0;
        @(posedge clk); @(negedge clk);
        chk("R7 disable mid period", 32'({clk_lane, lane_sd}), 32'd0);

        // Random modes, mappings and pixels (R1 to R6).
        for (int t = 0; t < 40; t++) begin
            rand_sel();
            cfg_depth24 = 1'($urandom);
            cfg_dual    = 1'($urandom);
            cfg_swap    = 1'($urandom);
            run_pixels(12, "R2 R3 R4 R5 R6 random", 1'b1);
            chk("R8 random flags", 32'({narrow_rgb, single_link}), 32'({!cfg_depth24, !cfg_dual}));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule